// File: doc/BRIEF.md
# Compressed Constant Expander

This block turns the short immediate field of a 32-bit instruction word into a full 32-bit constant and a carry flag. A mode input picks one of two compression schemes.

In the rotated-byte scheme, a low byte is rotated right by an even amount taken from a 4-bit count. In the split-field scheme, a 12-bit field is gathered from three separate places in the word. That field either copies one byte into a fixed lane pattern, or rotates a byte whose top bit is forced to one.

The block is one stream stage. A beat carrying an opcode, a mode and a carry-in is taken on a valid/ready handshake. The expanded result appears on the output side one cycle later.

Back-pressure rules:
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output beat is held unchanged and no new beat is taken.
- With `out_ready` held high, one beat passes per cycle.

Top module: `imm_expand`

## Requirements
- R1: With `in_mode`=0, the result is `in_opcode[7:0]`, zero-extended and rotated right within 32 bits by twice `in_opcode[11:8]`.
- R2: With `in_mode`=0, the carry out equals the carry-in when `in_opcode[11:8]` is zero; otherwise it equals bit 31 of the result.
- R3: With `in_mode`=1, the field F = {`in_opcode[26]`, `in_opcode[14:12]`, `in_opcode[7:0]`}; its low byte is B = F[7:0]. When F[11:10]=00, F[9:8] picks the lane pattern:
  - 00 gives B zero-extended.
  - 01 gives B in bytes 0 and 2.
  - 10 gives B in bytes 1 and 3.
  - 11 gives B in all four bytes.
- R4: In the lane-pattern cases of R3, the carry out equals the carry-in.
- R5: With `in_mode`=1 and F[11:10]≠00, the result is {1, F[6:0]}, zero-extended and rotated right by F[11:7]; the carry out is bit 31 of the result.
- R6: `out_unpred` is 1 exactly when `in_mode`=1, F[11:10]=00, F[9:8]≠00 and B=0. The result value is still driven in that case.
- R7: A beat accepted on a rising edge appears at the output with `out_valid`=1 after that edge. While `out_valid`=1 and `out_ready`=0, the output value, carry and flag stay stable.
- R8: After reset, and after any cycle in which the stage is drained and nothing enters, `out_valid` is 0.
- R9: `in_ready` is 1 when the stage is empty or `out_ready` is 1, and 0 when a held beat is stalled. Bits of `in_opcode` outside the fields used by the selected mode do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage can take a beat |
| in_opcode | input | 32 | Instruction word holding the immediate field |
| in_mode | input | 1 | 0 = rotated byte, 1 = split field |
| in_carry | input | 1 | Carry-in used where the carry passes through |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the output beat |
| out_imm | output | 32 | Expanded 32-bit constant |
| out_carry | output | 1 | Carry out |
| out_unpred | output | 1 | Lane pattern with a zero byte |

## Verification
The hardest states to reach from the ports are the two edges of the split-field decode:
- a zero byte under a non-trivial lane pattern, which raises the flag;
- the field values right at the boundary between lane patterns and forced-MSB rotation, such as F=0x3FF against F=0x400, and the maximal F=0xFFF.

Random opcodes almost never land on these, so the stimulus places them directly. Each field value is scattered into its three opcode positions, with noise in the unused bits.

Stalls are produced by dropping `out_ready` for several cycles while `in_valid` stays high. This checks that the held beat and `in_ready` behave correctly. A cycle-by-cycle model in the bench compares every output on every clock.

// File: rtl/imm_expand_pkg.sv
package imm_expand_pkg;
  localparam int WORD_W  = 32;
  localparam int BYTE_W  = 8;
  localparam int FIELD_W = 12;
  localparam int ROT_W   = $clog2(WORD_W);

  typedef enum logic {
    MODE_ROTBYTE = 1'b0,
    MODE_SPLIT   = 1'b1
  } exp_mode_e;

  typedef struct packed {
    logic [WORD_W-1:0] value;
    logic              carry;
    logic              unpred;
  } exp_result_t;
endpackage

// File: rtl/imm_rotr.sv
// Log-depth right rotator; amount taken modulo the width, zero passes through.
module imm_rotr #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [AW+1];

  assign stage[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt[s] ? {stage[s][SH-1:0], stage[s][W-1:SH]} : stage[s];
  end

  assign dout = stage[AW];
endmodule

// File: rtl/imm_rotbyte_dec.sv
// Rotated-byte scheme: byte rotated right by twice a 4-bit count.
module imm_rotbyte_dec
  import imm_expand_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  input  logic               carry_in,
  output exp_result_t        res
);
  localparam int CNT_W = FIELD_W - BYTE_W;

  logic [CNT_W-1:0] count;
  logic [ROT_W-1:0] amount;
  logic [WORD_W-1:0] rotated;

  assign count  = field[FIELD_W-1:BYTE_W];
  assign amount = ROT_W'({count, 1'b0});

  imm_rotr #(.W(WORD_W), .AW(ROT_W)) rot_i (
    .din  ({{(WORD_W-BYTE_W){1'b0}}, field[BYTE_W-1:0]}),
    .amt  (amount),
    .dout (rotated)
  );

  always_comb begin
    res.value  = rotated;
    res.carry  = (count == '0) ? carry_in : rotated[WORD_W-1];
    res.unpred = 1'b0;
  end
endmodule

// File: rtl/imm_split_dec.sv
// Split-field scheme: lane replication or forced-MSB rotation.
module imm_split_dec
  import imm_expand_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  input  logic               carry_in,
  output exp_result_t        res
);
  localparam int LANES = WORD_W / BYTE_W;

  logic [BYTE_W-1:0] lane_byte;
  logic [1:0]        top2;
  logic [1:0]        pattern;
  logic [WORD_W-1:0] replicated;
  logic [WORD_W-1:0] rotated;
  logic [LANES-1:0]  lane_on;

  assign lane_byte = field[BYTE_W-1:0];
  assign top2      = field[FIELD_W-1:FIELD_W-2];
  assign pattern   = field[FIELD_W-3:FIELD_W-4];

  always_comb begin
    unique case (pattern)
      2'b00:   lane_on = 4'b0001;
      2'b01:   lane_on = 4'b0101;
      2'b10:   lane_on = 4'b1010;
      default: lane_on = 4'b1111;
    endcase
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign replicated[l*BYTE_W +: BYTE_W] = lane_on[l] ? lane_byte : '0;
  end

  imm_rotr #(.W(WORD_W), .AW(ROT_W)) rot_i (
    .din  ({{(WORD_W-BYTE_W){1'b0}}, 1'b1, field[BYTE_W-2:0]}),
    .amt  (field[FIELD_W-1:FIELD_W-ROT_W]),
    .dout (rotated)
  );

  always_comb begin
    if (top2 == 2'b00) begin
      res.value  = replicated;
      res.carry  = carry_in;
      res.unpred = (pattern != 2'b00) && (lane_byte == '0);
    end else begin
      res.value  = rotated;
      res.carry  = rotated[WORD_W-1];
      res.unpred = 1'b0;
    end
  end
endmodule

// File: rtl/imm_expand.sv
module imm_expand
  import imm_expand_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_opcode,
  input  logic        in_mode,
  input  logic        in_carry,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_imm,
  output logic        out_carry,
  output logic        out_unpred
);
  logic [FIELD_W-1:0] rot_field;
  logic [FIELD_W-1:0] split_field;
  exp_result_t        rot_res;
  exp_result_t        split_res;
  exp_result_t        sel_res;
  exp_result_t        held;
  logic               take;
  logic               unused_opcode_bits;

  assign rot_field   = in_opcode[FIELD_W-1:0];
  assign split_field = {in_opcode[26], in_opcode[14:12], in_opcode[7:0]};
  assign unused_opcode_bits = ^{in_opcode[31:27], in_opcode[25:15]};

  imm_rotbyte_dec rotbyte_i (
    .field    (rot_field),
    .carry_in (in_carry),
    .res      (rot_res)
  );

  imm_split_dec split_i (
    .field    (split_field),
    .carry_in (in_carry),
    .res      (split_res)
  );

  assign sel_res  = (exp_mode_e'(in_mode) == MODE_SPLIT) ? split_res : rot_res;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      held      <= sel_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_imm    = held.value;
  assign out_carry  = held.carry;
  assign out_unpred = held.unpred;
endmodule

// File: rtl/imm_expand_chk.sv
module imm_expand_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_imm,
  input logic        out_carry,
  input logic        out_unpred
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_imm) && $stable(out_carry) && $stable(out_unpred));

  // R7
  accept_appears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8
  drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && out_ready |=> !out_valid);

  // R9
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R9
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R6
  unpred_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unpred |-> out_imm == 32'd0);
endmodule

bind imm_expand imm_expand_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_imm    (out_imm),
  .out_carry  (out_carry),
  .out_unpred (out_unpred)
);

// File: tb/imm_expand_tb_top.sv
`timescale 1ns/1ps
module imm_expand_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_opcode = '0;
  logic        in_mode = 1'b0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_imm;
  logic        out_carry;
  logic        out_unpred;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic        m_valid = 1'b0;
  logic [31:0] m_imm = '0;
  logic        m_carry = 1'b0;
  logic        m_unpred = 1'b0;
  string       m_vtag = "R1";
  string       m_ctag = "R2";

  always #5 clk = ~clk;

  imm_expand dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_mode(in_mode), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready), .out_imm(out_imm),
    .out_carry(out_carry), .out_unpred(out_unpred)
  );

  function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
    int k = n % 32;
    if (k == 0) return v;
    return (v >> k) | (v << (32 - k));
  endfunction

  task automatic calc(input logic [31:0] op, input logic md, input logic ci,
                      output logic [31:0] v, output logic c, output logic u,
                      output string vt, output string ct);
    logic [11:0] f;
    logic [7:0]  b;
    int          amt;
    if (!md) begin
      amt = 2 * int'(op[11:8]);
      v = rotr({24'd0, op[7:0]}, amt);
      c = (amt == 0) ? ci : v[31];
      u = 1'b0; vt = "R1"; ct = "R2";
    end else begin
      f = {op[26], op[14:12], op[7:0]};
      b = op[7:0];
      if (f[11:10] == 2'b00) begin
        case (f[9:8])
          2'd0: v = {24'd0, b};
          2'd1: v = {8'd0, b, 8'd0, b};
          2'd2: v = {b, 8'd0, b, 8'd0};
          default: v = {b, b, b, b};
        endcase
        c = ci;
        u = (f[9:8] != 2'd0) && (b == 8'd0);
        vt = "R3"; ct = "R4";
      end else begin
        v = rotr({24'd0, 1'b1, f[6:0]}, int'(f[11:7]));
        c = v[31];
        u = 1'b0; vt = "R5"; ct = "R5";
      end
    end
  endtask

  task automatic check1(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] place(input logic [11:0] f, input logic [31:0] noise);
    logic [31:0] op = noise & ~32'h0400_70FF;
    op[26] = f[11];
    op[14:12] = f[10:8];
    op[7:0] = f[7:0];
    return op;
  endfunction

  // drive one cycle at a negedge, update the model, compare at the next negedge
  task automatic step(input logic v, input logic [31:0] op, input logic md, input logic ci, input logic rdy);
    logic exp_ready;
    logic [31:0] nv;
    logic nc, nu;
    string vt, ct;
    in_valid = v; in_opcode = op; in_mode = md; in_carry = ci; out_ready = rdy;
    #1;
    exp_ready = !m_valid || rdy;
    check1("R9", "in_ready", {31'd0, in_ready}, {31'd0, exp_ready});
    if (v && exp_ready) begin
      calc(op, md, ci, nv, nc, nu, vt, ct);
      m_valid = 1'b1; m_imm = nv; m_carry = nc; m_unpred = nu; m_vtag = vt; m_ctag = ct;
    end else if (rdy) begin
      m_valid = 1'b0;
    end
    @(negedge clk);
    check1("R7", "out_valid", {31'd0, out_valid}, {31'd0, m_valid});
    if (m_valid) begin
      check1(m_vtag, "out_imm", out_imm, m_imm);
      check1(m_ctag, "out_carry", {31'd0, out_carry}, {31'd0, m_carry});
      check1("R6", "out_unpred", {31'd0, out_unpred}, {31'd0, m_unpred});
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    check1("R8", "out_valid after reset", {31'd0, out_valid}, 32'd0);

    // R1 R2 rotated-byte corners
    step(1, 32'hFFFF_F0FF, 0, 1, 1);
    step(1, 32'h0000_00FF, 0, 1, 1);
    step(1, 32'h0000_04FF, 0, 1, 1);
    step(1, 32'h0000_01FF, 0, 0, 1);
    step(1, 32'h0000_0F01, 0, 1, 1);
    step(1, 32'h0000_0180, 0, 0, 1);
    // R3 R4 lane patterns with noise in ignored bits (R9)
    for (int p = 0; p < 4; p++) step(1, place({2'b00, p[1:0], 8'hA5}, 32'hF3F8_8F00), 1, 1, 1);
    for (int p = 0; p < 4; p++) step(1, place({2'b00, p[1:0], 8'h5A}, 32'h0000_0000), 1, 0, 1);
    // R6 zero byte under each pattern
    for (int p = 0; p < 4; p++) step(1, place({2'b00, p[1:0], 8'h00}, 32'hABCD_EF00), 1, 1, 1);
    // R5 boundaries
    step(1, place(12'h3FF, 32'h0), 1, 0, 1);
    step(1, place(12'h400, 32'h0), 1, 0, 1);
    step(1, place(12'h47F, 32'hFFFF_FFFF), 1, 1, 1);
    step(1, place(12'hFFF, 32'h0), 1, 1, 1);
    step(1, place(12'h800, 32'h0), 1, 0, 1);
    // R7 stall with new data waiting, R8 drain
    step(1, 32'h0000_02C3, 0, 1, 0);
    step(1, 32'h0000_0311, 0, 0, 0);
    step(1, 32'h0000_0522, 0, 0, 0);
    step(1, 32'h0000_0522, 0, 0, 1);
    step(0, 32'h0, 0, 0, 1);
    step(0, 32'h0, 0, 0, 1);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 3) != 0), $urandom, 1'($urandom), 1'($urandom),
           1'($urandom_range(0, 3) != 0));
    end
    step(0, 32'h0, 0, 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule